// File: doc/BRIEF.md
# Instruction Reuse Classifier Table

This block keeps a direct-mapped table of saturating counters, one per slot, selected by the address of the memory instruction that performs an access. Each time an access by some instruction turns out to reuse data already held nearby, the slot for that instruction counts up. Each time the access is a first touch of a line, the slot counts down. Over time a slot comes to say how much of the data fetched by that instruction is ever used again.

A lookup port takes an instruction address and, one clock later, reports one of five ordered reuse classes for that instruction. The classes run from "skip caching" through "rarely used", "ordinary" and "often used" up to "heavily reused". A cache insertion policy uses that class to choose where a new line goes. An update port takes an instruction address and a reuse/first-touch flag. Both ports may act in the same cycle, on the same slot or on different slots.

Top module: `pc_reuse_table`

## Requirements
- R1: The slot index is bits [10:2] of the instruction address (9 bits, 512 slots). Address bits [1:0] and bits [31:11] do not select the slot.
- R2: After reset every counter holds 128, so every lookup reports class NORMAL (code 2).
- R3: An update with `upd_reuse`=1 raises the selected counter by one and stops at 255. An update with `upd_reuse`=0 lowers it by one and stops at 0.
- R4: The class codes are decoded from the counter value as follows: BYPASS=0 for 0..15, USELESS=1 for 16..95, NORMAL=2 for 96..159, USEFUL=3 for 160..239, REUSE=4 for 240..255.
- R5: `res_valid` is high in exactly the cycle after a cycle with `lkp_valid` high. In that cycle `res_class` carries the class of the addressed slot. While no lookup is made, `res_class` keeps its last value.
- R6: When a lookup and an update select the same slot in the same cycle, the lookup reports the class of the counter value from before that update.
- R7: An update changes only the slot it selects; every other slot keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_pc | input | 32 | Instruction address for the lookup |
| upd_valid | input | 1 | Update request this cycle |
| upd_pc | input | 32 | Instruction address for the update |
| upd_reuse | input | 1 | 1 = data reuse (count up), 0 = first touch (count down) |
| res_valid | output | 1 | Lookup result present |
| res_class | output | 3 | Reuse class code of the looked-up slot |

## Verification
The saturation and step properties assume that at most one update reaches a slot per cycle and that the update flag is stable while `upd_valid` is high. The single update port guarantees the first. The stimulus drives every input at the falling edge and holds it for a full cycle, which guarantees the second. The lookup timing properties assume that `lkp_valid` is never X after reset. The stimulus drives it to a known level from time zero. A single slot is swept from the midpoint down past zero and up past the top, so every class boundary and both saturation points are crossed.

// File: rtl/pc_reuse_pkg.sv
package pc_reuse_pkg;
   typedef enum logic [2:0] {
      RC_BYPASS  = 3'd0,
      RC_USELESS = 3'd1,
      RC_NORMAL  = 3'd2,
      RC_USEFUL  = 3'd3,
      RC_REUSE   = 3'd4
   } reuse_cls_e;

   localparam int unsigned CLS_W = 3;
endpackage

// File: rtl/pc_reuse_index.sv
module pc_reuse_index #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned IDX_W     = 9,
   parameter int unsigned IDX_LSB   = 2,
   parameter bit          FOLD_HASH = 1'b0
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   if (IDX_LSB + IDX_W > PC_W) begin : g_bad_slice
      $error("pc_reuse_index: index slice exceeds address width");
   end

   if (FOLD_HASH) begin : g_fold
      if (IDX_LSB + 2*IDX_W > PC_W) begin : g_bad_fold
         $error("pc_reuse_index: folded hash needs two index slices");
      end
      always_comb begin
         idx = pc[IDX_LSB +: IDX_W] ^ pc[IDX_LSB+IDX_W +: IDX_W];
      end
   end else begin : g_slice
      always_comb begin
         idx = pc[IDX_LSB +: IDX_W];
      end
   end
endmodule

// File: rtl/pc_reuse_bank.sv
module pc_reuse_bank #(
   parameter int unsigned IDX_W   = 9,
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned INIT_V  = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_val,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CMIN  = '0;
   localparam logic [CNT_W-1:0] CINIT = CNT_W'(INIT_V);

   if (INIT_V > (1 << CNT_W) - 1) begin : g_bad_init
      $error("pc_reuse_bank: reset value does not fit the counter");
   end

   logic [CNT_W-1:0] ctr_q [DEPTH];
   logic [CNT_W-1:0] wr_old;
   logic [CNT_W-1:0] wr_new;

   always_comb begin
      wr_old = ctr_q[wr_idx];
      wr_new = wr_old;
      if (wr_up && wr_old != CMAX) begin
         wr_new = wr_old + 1'b1;
      end else if (!wr_up && wr_old != CMIN) begin
         wr_new = wr_old - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            ctr_q[i] <= CINIT;
         end
      end else if (wr_en) begin
         ctr_q[wr_idx] <= wr_new;
      end
   end

   assign rd_val = ctr_q[rd_idx];

   // R3: one step up on reuse, held at the top
   a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_up && ctr_q[wr_idx] != CMAX
      |=> ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) + 1'b1);
   a_r3_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_up && ctr_q[wr_idx] == CMAX
      |=> ctr_q[$past(wr_idx)] == CMAX);
   // R3: one step down on first touch, held at zero
   a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_up && ctr_q[wr_idx] != CMIN
      |=> ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) - 1'b1);
   a_r3_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_up && ctr_q[wr_idx] == CMIN
      |=> ctr_q[$past(wr_idx)] == CMIN);
   // R7: with no update, the read slot keeps its value
   a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ctr_q[$past(rd_idx)] == $past(rd_val));
endmodule

// File: rtl/pc_reuse_decode.sv
module pc_reuse_decode
   import pc_reuse_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned TH_USELSS = 16,
   parameter int unsigned TH_NORMAL = 96,
   parameter int unsigned TH_USEFUL = 160,
   parameter int unsigned TH_REUSE  = 240
) (
   input  logic [CNT_W-1:0] val,
   output reuse_cls_e       cls
);
   if (!(TH_USELSS < TH_NORMAL && TH_NORMAL < TH_USEFUL &&
         TH_USEFUL < TH_REUSE && TH_REUSE <= (1 << CNT_W) - 1)) begin : g_bad_th
      $error("pc_reuse_decode: thresholds must rise and fit the counter");
   end

   localparam logic [CNT_W-1:0] T1 = CNT_W'(TH_USELSS);
   localparam logic [CNT_W-1:0] T2 = CNT_W'(TH_NORMAL);
   localparam logic [CNT_W-1:0] T3 = CNT_W'(TH_USEFUL);
   localparam logic [CNT_W-1:0] T4 = CNT_W'(TH_REUSE);

   always_comb begin
      if (val >= T4)      cls = RC_REUSE;
      else if (val >= T3) cls = RC_USEFUL;
      else if (val >= T2) cls = RC_NORMAL;
      else if (val >= T1) cls = RC_USELESS;
      else                cls = RC_BYPASS;
   end
endmodule

// File: rtl/pc_reuse_table.sv
module pc_reuse_table
   import pc_reuse_pkg::*;
#(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned IDX_W     = 9,
   parameter int unsigned IDX_LSB   = 2,
   parameter bit          FOLD_HASH = 1'b0,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned INIT_V    = 128,
   parameter int unsigned TH_USELSS = 16,
   parameter int unsigned TH_NORMAL = 96,
   parameter int unsigned TH_USEFUL = 160,
   parameter int unsigned TH_REUSE  = 240
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lkp_valid,
   input  logic [PC_W-1:0] lkp_pc,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_reuse,
   output logic            res_valid,
   output logic [2:0]      res_class
);
   logic [IDX_W-1:0] lkp_idx;
   logic [IDX_W-1:0] upd_idx;
   logic [CNT_W-1:0] lkp_val;
   reuse_cls_e       lkp_cls;

   pc_reuse_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB),
                    .FOLD_HASH(FOLD_HASH)) u_idx_lkp (
      .pc(lkp_pc), .idx(lkp_idx));

   pc_reuse_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB),
                    .FOLD_HASH(FOLD_HASH)) u_idx_upd (
      .pc(upd_pc), .idx(upd_idx));

   pc_reuse_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W), .INIT_V(INIT_V)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lkp_idx), .rd_val(lkp_val),
      .wr_en(upd_valid), .wr_idx(upd_idx), .wr_up(upd_reuse));

   pc_reuse_decode #(.CNT_W(CNT_W), .TH_USELSS(TH_USELSS),
                     .TH_NORMAL(TH_NORMAL), .TH_USEFUL(TH_USEFUL),
                     .TH_REUSE(TH_REUSE)) u_dec (
      .val(lkp_val), .cls(lkp_cls));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_class <= RC_NORMAL;
      end else begin
         res_valid <= lkp_valid;
         if (lkp_valid) begin
            res_class <= lkp_cls;
         end
      end
   end

   // R5: result strobe follows a lookup by one cycle
   a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_valid |=> res_valid);
   a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_valid |=> !res_valid);
   a_r5_class_held: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_valid |=> $stable(res_class));
   // R4: only the five defined codes appear
   a_r4_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      res_class <= 3'd4);
endmodule

// File: tb/pc_reuse_table_test.sv
`timescale 1ns/1ps
module pc_reuse_table_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lkp_valid = 1'b0;
   logic [31:0] lkp_pc = '0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_reuse = 1'b0;
   logic        res_valid;
   logic [2:0]  res_class;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pc_reuse_table uut (
      .clk(clk), .rst_n(rst_n),
      .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_reuse(upd_reuse),
      .res_valid(res_valid), .res_class(res_class));

   function automatic int cls_of(int v);
      if (v >= 240) return 4;
      if (v >= 160) return 3;
      if (v >= 96)  return 2;
      if (v >= 16)  return 1;
      return 0;
   endfunction

   function automatic logic [31:0] pc_of(int idx, int hi, int lo);
      return (32'(hi) << 11) | (32'(idx) << 2) | 32'(lo & 3);
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: optional update and lookup, result checked after the edge
   task automatic step(bit dl, logic [31:0] lpc, bit du, logic [31:0] upc,
                       bit up);
      @(negedge clk);
      lkp_valid = dl; lkp_pc = lpc;
      upd_valid = du; upd_pc = upc; upd_reuse = up;
      @(negedge clk);
      lkp_valid = 1'b0; upd_valid = 1'b0;
   endtask

   task automatic look(string req, logic [31:0] pc, int exp);
      step(1'b1, pc, 1'b0, '0, 1'b0);
      check(req, int'(res_valid), 1);
      check(req, int'(res_class), exp);
   endtask

   initial begin
      int m;
      int prev;
      repeat (3) @(negedge clk);
      // R5 / R2 reset state
      check("R5 reset valid", int'(res_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 idle valid", int'(res_valid), 0);
      // R2: every slot starts NORMAL
      for (int i = 0; i < 512; i++) begin
         look("R2", pc_of(i, i * 7, i), 2);
      end
      // R1: 40 first touches to slot 7 via aliasing addresses -> 88 USELESS
      for (int k = 0; k < 40; k++) begin
         step(1'b0, '0, 1'b1, pc_of(7, k * 13 + 1, k), 1'b0);
      end
      look("R1 alias", pc_of(7, 0, 0), 1);
      look("R1 alias hi", pc_of(7, 1000, 3), 1);
      // R5: class held while idle
      @(negedge clk);
      check("R5 held class", int'(res_class), 1);
      check("R5 no strobe", int'(res_valid), 0);
      // R7: neighbours untouched
      look("R7 slot6", pc_of(6, 0, 0), 2);
      look("R7 slot8", pc_of(8, 0, 0), 2);
      // R3/R4/R6 sweep of slot 20: down past 0, then up past 255
      m = 128;
      for (int s = 0; s < 140; s++) begin
         prev = m;
         step(1'b1, pc_of(20, 5, 0), 1'b1, pc_of(20, 9, 1), 1'b0);
         check("R6 old value", int'(res_class), cls_of(prev));
         if (m > 0) m--;
         look("R3/R4 down", pc_of(20, 0, 2), cls_of(m));
      end
      for (int s = 0; s < 270; s++) begin
         prev = m;
         step(1'b1, pc_of(20, 3, 3), 1'b1, pc_of(20, 2, 0), 1'b1);
         check("R6 old value", int'(res_class), cls_of(prev));
         if (m < 255) m++;
         look("R3/R4 up", pc_of(20, 0, 0), cls_of(m));
      end
      // R3: from the top, 16 first touches -> 239 USEFUL
      for (int s = 0; s < 16; s++) begin
         step(1'b0, '0, 1'b1, pc_of(20, 0, 0), 1'b0);
      end
      look("R3 off top", pc_of(20, 0, 0), 3);
      // R7: other slots still as before
      look("R7 slot19", pc_of(19, 0, 0), 2);
      look("R7 slot7", pc_of(7, 0, 0), 1);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule